// File: doc/BRIEF.md
# Translation Table Walker

This block turns a 48-bit input address into an output address by walking a tree of 64-bit descriptors stored in memory. A caller presents the input address, the byte address of the top table, the level at which the walk starts (0 to 3) and a granule code. For each level the walker computes a table index from the input address, fetches one descriptor over a simple request/response memory port, and decides whether to descend, to finish with a mapping, or to stop with a fault.

Levels are numbered in walk order: the start level is the top of the tree and level 3 is the last. The granule sets how many input bits each level consumes. When the walk ends, one result pulse carries one of two things. On success it gives the output address and the leaf's attributes, with restrictions gathered from every table descriptor passed on the way down. On failure it gives a fault code and the level that faulted. Only one walk is in progress at a time.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req_valid` and `done_valid` are 0 and `done_fault` is 0.
- R2: A request is taken only in a cycle with `busy` low. `busy` is 1 from the cycle after acceptance until the cycle of the result pulse. While `busy` is high, `req_valid` and the request fields have no effect: the result matches the first request, no extra descriptor reads occur, and no second result follows.
- R3: `req_gran` 0, 1 and 2 select page shifts gs of 12, 14 and 16. At level L the index is (input address >> (gs + (3-L)*(gs-3))) masked to gs-3 bits. The read address is the current table base plus 8 times that index.
- R4: A valid descriptor (bit 0 set) with bit 1 set at levels 0 to 2 is a table pointer. The walk moves to level L+1 with table base {bits 47:12, 12'b0}, and there is exactly one read per level visited.
- R5: A leaf is a valid descriptor with bit 1 clear at levels 0 to 2 (block), or with bit 1 set at level 3 (page). Its output address takes {bits 47:12, 12'b0} above the level shift and the input address below it. `done_level` reports the leaf level and `done_fault` is 0.
- R6: A translation fault (`done_fault` = 1) ends the walk when a descriptor has bit 0 clear at any level, or when a valid level-3 descriptor has bit 1 clear. `done_level` is the level of that descriptor. On any fault `done_pa` and `done_attr` are 0.
- R7: A valid descriptor (table or leaf) with any of bits 51:48 set ends the walk with an address-size fault (`done_fault` = 2). This check is made after the valid check and before the level-3 type check.
- R8: `done_attr` layout is [2:0] = leaf bits 4:2, [3] = leaf bit 5 OR any table bit 63, [4] = leaf bit 6 AND NOT any table bit 61, [5] = leaf bit 7 OR any table bit 62, [7:6] = leaf bits 9:8, [8] = leaf bit 10, [9] = leaf bit 11, [10] = leaf bit 52, [11] = leaf bit 53 OR any table bit 59, [12] = leaf bit 54 OR any table bit 60, [16:13] = leaf bits 58:55. Table bits 11:2 and 58:52 have no effect.
- R9: `done_valid` is high for exactly one cycle per walk, with `busy` low in that cycle. A new request presented in that same cycle is accepted.
- R10: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_va | input | 48 | Input address to translate |
| req_root | input | 48 | Byte address of the starting table |
| req_level | input | 2 | Starting level |
| req_gran | input | 2 | Granule code: 0 = 4K, 1 = 16K, 2 = 64K |
| busy | output | 1 | Walk in progress; requests are ignored |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor read data |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 2 | 0 none, 1 translation, 2 address size |
| done_level | output | 2 | Leaf or faulting level |
| done_pa | output | 48 | Output address |
| done_attr | output | 17 | Merged leaf attributes |

## Verification
The overlap that matters is the result pulse of one walk falling in the same cycle as the acceptance of the next. The bench provokes it on every walk of its sweep by presenting each new request in the very cycle it sees `done_valid`. It judges the outcome by checking that the finished result is intact in that cycle and that the new walk's reads and result match the computed ones. A second overlap is a request held high while a walk is active and the memory stalls at random. There the bench judges that the active walk's reads, result and count of pulses are unchanged.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W   = 48;
  localparam int DESC_W = 64;
  localparam int ATTR_W = 17;
  localparam int HIER_W = 5;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLAT  = 2'd1,
    FLT_ASIZE = 2'd2
  } flt_e;

  // page shift of the selected granule
  function automatic int gran_shift(input logic [1:0] gran);
    case (gran)
      2'd1:    return 14;
      2'd2:    return 16;
      default: return 12;
    endcase
  endfunction

  // position of the lowest input bit resolved at a level
  function automatic logic [6:0] lvl_shift(input logic [1:0] gran, input logic [1:0] lvl);
    int gs;
    int lv;
    gs = gran_shift(gran);
    lv = int'(lvl);
    return 7'(gs + (3 - lv) * (gs - 3));
  endfunction

  function automatic logic [63:0] idx_mask(input logic [1:0] gran);
    return (64'd1 << (gran_shift(gran) - 3)) - 64'd1;
  endfunction

  function automatic logic [63:0] low_mask(input logic [6:0] sh);
    return (64'd1 << sh) - 64'd1;
  endfunction

endpackage

// File: rtl/xlat_index_gen.sv
module xlat_index_gen
  import xlat_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] va,
  input  logic [1:0]    gran,
  input  logic [1:0]    lvl,
  output logic [AW-1:0] rd_addr
);
  localparam int PADW = 64 - AW;

  logic [63:0]   va_ext;
  logic [6:0]    sh;
  logic [AW-1:0] idx;

  always_comb begin
    va_ext  = {{PADW{1'b0}}, va};
    sh      = lvl_shift(gran, lvl);
    idx     = AW'((va_ext >> sh) & idx_mask(gran));
    rd_addr = tbl_base + (idx << 3);
  end
endmodule

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
  import xlat_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        lvl,
  input  logic [HIER_W-1:0] hier_in,
  output flt_e              flt,
  output logic              is_next,
  output logic [VA_W-1:0]   base,
  output logic [HIER_W-1:0] hier_out,
  output logic [ATTR_W-1:0] attr
);
  logic valid, tbit, last, mbz_bad;

  always_comb begin
    valid   = desc[0];
    tbit    = desc[1];
    last    = (lvl == 2'd3);
    mbz_bad = |desc[51:48];

    if (!valid)             flt = FLT_XLAT;
    else if (mbz_bad)       flt = FLT_ASIZE;
    else if (last && !tbit) flt = FLT_XLAT;
    else                    flt = FLT_NONE;

    is_next  = valid && tbit && !last;
    base     = {desc[47:12], 12'h000};
    // {ns, ro, no_user, xn, pxn} gathered from table bits 63:59
    hier_out = hier_in | desc[63:59];

    attr = {desc[58:55],
            desc[54] | hier_in[1],
            desc[53] | hier_in[0],
            desc[52],
            desc[11],
            desc[10],
            desc[9:8],
            desc[7] | hier_in[3],
            desc[6] & ~hier_in[2],
            desc[5] | hier_in[4],
            desc[4:2]};
  end
endmodule

// File: rtl/xlat_out_addr.sv
module xlat_out_addr
  import xlat_pkg::*;
#(
  parameter int AW = VA_W
) (
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] va,
  input  logic [1:0]    gran,
  input  logic [1:0]    lvl,
  output logic [AW-1:0] pa
);
  logic [6:0] sh;

  always_comb begin
    sh = lvl_shift(gran, lvl);
    pa = (desc_base & ~AW'(low_mask(sh))) | (va & AW'(low_mask(sh)));
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic [VA_W-1:0]   req_root,
  input  logic [1:0]        req_level,
  input  logic [1:0]        req_gran,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              done_valid,
  output logic [1:0]        done_fault,
  output logic [1:0]        done_level,
  output logic [VA_W-1:0]   done_pa,
  output logic [ATTR_W-1:0] done_attr
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;

  st_e               st;
  logic [VA_W-1:0]   va_q, tbase_q;
  logic [1:0]        lvl_q, gran_q;
  logic [HIER_W-1:0] hier_q;

  flt_e              dec_flt;
  logic              dec_next;
  logic [VA_W-1:0]   dec_base, leaf_pa;
  logic [HIER_W-1:0] dec_hier;
  logic [ATTR_W-1:0] dec_attr;

  // named events for the checker
  logic ev_accept, ev_descend, ev_finish;

  xlat_index_gen #(.AW(VA_W)) u_idx (
    .tbl_base(tbase_q), .va(va_q), .gran(gran_q), .lvl(lvl_q), .rd_addr(mem_req_addr)
  );

  xlat_desc_decode u_dec (
    .desc(mem_rsp_data), .lvl(lvl_q), .hier_in(hier_q),
    .flt(dec_flt), .is_next(dec_next), .base(dec_base),
    .hier_out(dec_hier), .attr(dec_attr)
  );

  xlat_out_addr #(.AW(VA_W)) u_pa (
    .desc_base(dec_base), .va(va_q), .gran(gran_q), .lvl(lvl_q), .pa(leaf_pa)
  );

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign ev_accept     = (st == S_IDLE) && req_valid;
  assign ev_descend    = (st == S_WAIT) && mem_rsp_valid && (dec_flt == FLT_NONE) && dec_next;
  assign ev_finish     = (st == S_WAIT) && mem_rsp_valid && !ev_descend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      tbase_q    <= '0;
      lvl_q      <= '0;
      gran_q     <= '0;
      hier_q     <= '0;
      done_valid <= 1'b0;
      done_fault <= '0;
      done_level <= '0;
      done_pa    <= '0;
      done_attr  <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (ev_accept) begin
          va_q    <= req_va;
          tbase_q <= req_root;
          lvl_q   <= req_level;
          gran_q  <= req_gran;
          hier_q  <= '0;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: begin
          if (ev_descend) begin
            lvl_q   <= lvl_q + 2'd1;
            tbase_q <= dec_base;
            hier_q  <= dec_hier;
            st      <= S_ISSUE;
          end else if (ev_finish) begin
            st         <= S_IDLE;
            done_valid <= 1'b1;
            done_fault <= dec_flt;
            done_level <= lvl_q;
            done_pa    <= (dec_flt == FLT_NONE) ? leaf_pa  : '0;
            done_attr  <= (dec_flt == FLT_NONE) ? dec_attr : '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr,
  input logic            done_valid,
  input logic [1:0]      done_fault,
  input logic [VA_W-1:0] done_pa,
  input logic [VA_W-1:0] va_q,
  input logic [1:0]      lvl_q,
  input logic            ev_descend
);
  // R1: no read is requested while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R2: captured request stays fixed while a walk runs
  p_hold_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(va_q));

  // R4: a table pointer moves the walk one level down
  p_level_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> (lvl_q == $past(lvl_q) + 2'd1));

  // R5: the bits below 4 KiB always come from the input address on success
  p_page_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault == 2'd0) |-> (done_pa[11:0] == va_q[11:0]));

  // R9: result is a single-cycle pulse with the walker idle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  p_idle_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);

  // R10: a stalled read keeps its request and address
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done_valid(done_valid),
  .done_fault(done_fault), .done_pa(done_pa),
  .va_q(va_q), .lvl_q(lvl_q), .ev_descend(ev_descend)
);

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [47:0] req_va, req_root;
  logic [1:0]  req_level, req_gran;
  logic        busy, mem_req_valid, mem_req_ready, mem_rsp_valid, done_valid;
  logic [47:0] mem_req_addr, done_pa;
  logic [63:0] mem_rsp_data;
  logic [1:0]  done_fault, done_level;
  logic [16:0] done_attr;

  always #4 clk = ~clk;

  xlat_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_root(req_root), .req_level(req_level), .req_gran(req_gran),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
    .done_fault(done_fault), .done_level(done_level),
    .done_pa(done_pa), .done_attr(done_attr)
  );

  logic [63:0] mem [logic [47:0]];
  logic [47:0] rd_log [int];
  int          tot_rd = 0;
  int          nvec = 0;
  int          nfail = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  logic [1:0]  e_code, e_lvl;
  logic [47:0] e_pa;
  logic [16:0] e_attr;
  int          e_nrd;
  logic [47:0] e_addr [4];

  function automatic logic [63:0] mrd(input logic [47:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h000F_0000_0000_0003;
  endfunction

  function logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic int sh_of(input int g, input int lv);
    int gs;
    gs = 12 + 2 * g;
    return gs * (4 - lv) - 3 * (3 - lv);
  endfunction

  function automatic logic [47:0] slot(input logic [47:0] base, input logic [47:0] va,
                                       input int g, input int lv);
    logic [63:0] v, ix;
    v  = {16'h0, va};
    ix = (v >> sh_of(g, lv)) % (64'd1 << (9 + 2 * g));
    return base + 48'(ix * 8);
  endfunction

  // memory responder: random ready, data one cycle after the handshake
  initial begin
    logic [7:0]  lf;
    logic [47:0] a;
    lf = 8'hA5;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_req_ready = lf[0] | lf[1];
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        rd_log[tot_rd] = a;
        tot_rd = tot_rd + 1;
        @(negedge clk);
        mem_rsp_data  = mrd(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic hang(input string tag);
    nfail++;
    $display("FAIL %s watchdog expired actual=hung expected=done", tag);
    finish_run();
  endtask

  // independent walk model over the bench memory
  task automatic model(input logic [47:0] va, input logic [47:0] root, input int g, input int s);
    logic [47:0] tb, a;
    logic [63:0] d, m;
    logic [4:0]  h;
    bit          fin;
    tb = root; h = '0; fin = 0;
    e_nrd = 0; e_code = 0; e_pa = '0; e_attr = '0; e_lvl = '0;
    for (int lv = s; lv <= 3 && !fin; lv++) begin
      a = slot(tb, va, g, lv);
      d = mrd(a);
      e_addr[e_nrd] = a;
      e_nrd++;
      e_lvl = 2'(lv);
      if (!d[0]) begin e_code = 2'd1; fin = 1; end
      else if (d[51:48] != 4'h0) begin e_code = 2'd2; fin = 1; end
      else if (lv == 3 && !d[1]) begin e_code = 2'd1; fin = 1; end
      else if (lv < 3 && d[1]) begin h = h | d[63:59]; tb = {d[47:12], 12'h000}; end
      else begin
        m = (64'd1 << sh_of(g, lv)) - 64'd1;
        e_pa = ({d[47:12], 12'h000} & ~m[47:0]) | (va & m[47:0]);
        e_attr[2:0]   = d[4:2];
        e_attr[3]     = d[5] | h[4];
        e_attr[4]     = d[6] & ~h[2];
        e_attr[5]     = d[7] | h[3];
        e_attr[7:6]   = d[9:8];
        e_attr[8]     = d[10];
        e_attr[9]     = d[11];
        e_attr[10]    = d[52];
        e_attr[11]    = d[53] | h[0];
        e_attr[12]    = d[54] | h[1];
        e_attr[16:13] = d[58:55];
        fin = 1;
      end
    end
  endtask

  // build a chain of tables from level s down to leaf level t; kind selects the end
  task automatic build(input int g, input int s, input int t, input int k,
                       input logic [47:0] va, input logic [47:0] root);
    logic [47:0] tb, nb, a;
    logic [63:0] r, d;
    mem.delete();
    tb = root;
    for (int lv = s; lv <= t; lv++) begin
      a = slot(tb, va, g, lv);
      r = rnd();
      if (lv < t) begin
        nb = 48'h0000_2000_0000 + (48'(lv + 1) << 20);
        d  = {r[63:52], 4'h0, nb[47:12], r[11:2], 2'b11};
        tb = nb;
      end else begin
        case (k)
          0: d = {r[63:52], 4'h0, r[47:12], r[11:2], (lv == 3) ? 2'b11 : 2'b01};
          1: d = {r[63:52], 4'h0, r[47:12], r[11:2], r[1], 1'b0};
          2: d = {r[63:52], 4'h5, r[47:12], r[11:2], (lv == 3) ? 2'b11 : 2'b01};
          default: d = (lv == 3) ? {r[63:52], 4'h0, r[47:12], r[11:2], 2'b01}
                                 : {r[63:52], 4'h8, r[47:12], r[11:2], 2'b11};
        endcase
      end
      mem[a] = d;
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
      if (n > 200) hang("R9");
    end
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done_valid) begin
      @(negedge clk);
      n++;
      if (n > 400) hang("R9");
    end
  endtask

  task automatic check_result(input int r0);
    string ft;
    ft = (e_code == 2'd2) ? "R7" : ((e_code == 2'd1) ? "R6" : "R5");
    chk({ft, " fault code"}, 64'(done_fault), 64'(e_code));
    chk({ft, " level"}, 64'(done_level), 64'(e_lvl));
    chk("R5 output address", 64'(done_pa), 64'(e_pa));
    chk("R8 attributes", 64'(done_attr), 64'(e_attr));
    chk("R4 read count", 64'(tot_rd - r0), 64'(e_nrd));
    for (int i = 0; i < e_nrd && i < 4; i++)
      chk("R3 R10 read address", 64'(rd_log[r0 + i]), 64'(e_addr[i]));
  endtask

  task automatic launch(input logic [47:0] va, input logic [47:0] root, input int s, input int g);
    req_va    = va;
    req_root  = root;
    req_level = 2'(s);
    req_gran  = 2'(g);
    req_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [47:0] va, root;
    int          r0, rds;
    root      = 48'h0000_1000_0000;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_va    = '0;
    req_root  = '0;
    req_level = '0;
    req_gran  = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    chk("R1 done_valid after reset", 64'(done_valid), 64'd0);
    chk("R1 done_fault after reset", 64'(done_fault), 64'd0);

    // sweep: every granule, start level, leaf level and ending kind.
    // Each new request goes out in the cycle the previous result pulses (R9).
    for (int g = 0; g < 3; g++)
      for (int s = 0; s < 4; s++)
        for (int t = s; t < 4; t++)
          for (int k = 0; k < 4; k++)
            for (int v = 0; v < 2; v++) begin
              va = 48'(rnd());
              build(g, s, t, k, va, root);
              model(va, root, g, s);
              wait_idle();
              r0 = tot_rd;
              launch(va, root, s, g);
              req_valid = 1'b0;
              chk("R2 busy after accept", 64'(busy), 64'd1);
              wait_done();
              check_result(r0);
            end

    // requests while busy are ignored (R2), result pulse is single (R9)
    va = 48'(rnd());
    build(0, 0, 3, 0, va, root);
    model(va, root, 0, 0);
    wait_idle();
    r0 = tot_rd;
    launch(va, root, 0, 0);
    req_va    = ~va;
    req_root  = 48'h0000_3000_0000;
    req_level = 2'd3;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check_result(r0);
    @(negedge clk);
    chk("R9 pulse width", 64'(done_valid), 64'd0);
    chk("R9 idle after result", 64'(busy), 64'd0);
    rds = tot_rd;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done_valid || busy) chk("R2 no second walk", 64'(done_valid | busy), 64'd0);
    end
    chk("R2 no extra reads", 64'(tot_rd), 64'(rds));

    finish_run();
  end
endmodule